// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin-Sampled Bit Operations

This block is one general-purpose I/O port of a small controller. Each pin has an output data latch and a direction bit. A direction bit of 1 makes the pin an input, so its driver is released. A direction bit of 0 makes the pin drive its latch value. A core issues at most one port command per instruction cycle. Each instruction cycle is four clocks long, and these four clocks are the phases Q1, Q2, Q3 and Q4.

The command set is:
- write a full byte to the latch;
- set one bit;
- clear one bit;
- read the pins;
- load the direction register.

Single-bit set and clear do not read the latch. They take the levels sampled on the pins, change the addressed bit, and write the whole result back into the latch. An input pin therefore copies its external level into its own latch bit.

The pins are sampled on the edge that starts an instruction. The latch and direction updates land on the edge that ends it. A read issued in the instruction directly after a write therefore still sees the level from before the write. Only the low `IMPL_W` bits exist. The upper bits stay zero and undriven.

Top module: `gpio_rmw_port`

## Requirements
- R1: While reset is asserted, and right after it, `pin_out` is 0x00, `pin_oe` is 0x00 (every direction bit is 1, so every pin is an input), and `rd_valid` is 0.
- R2: `cyc_phase` encodes Q1=0, Q2=1, Q3=2, Q4=3. It resets to 3 and then advances by one on every clock, wrapping from 3 to 0. A command is taken on the clock edge that ends a cycle in which `cyc_phase` is 3.
- R3: WRITE (op code 0) loads the implemented bits of `op_data` into the latch. The new value appears on `pin_out` after the fourth clock edge following the edge that took the command.
- R4: BSET (op code 1) and BCLR (op code 2) take the pin levels sampled when the command is taken, force bit `op_bit` to 1 or 0 respectively, and write all bits of the result into the latch. Input pins therefore overwrite their own latch bits with their external level.
- R5: DIRLOAD (op code 4) loads `op_data` into the direction register with the same commit timing as R3. `pin_oe` is the bitwise inverse of the direction register on the implemented bits.
- R6: READ (op code 3) returns, on `rd_data`, the pin levels sampled on the edge that took the command. `rd_valid` is high for exactly the Q4 clock of that instruction and is low at all other times.
- R7: A READ taken in the instruction directly after a WRITE returns the pin levels from before that write. A READ one instruction later returns the new levels.
- R8: The bits at and above `IMPL_W` (bits 7:6 by default) read as 0 on `pin_out`, `pin_oe` and `rd_data` at all times. WRITE, BSET, BCLR and DIRLOAD leave them unchanged, including a BSET addressed to one of them.
- R9: A cycle whose `cyc_phase` is 3 but whose `op_valid` is low changes no state. A command held valid only during phases 0 to 2 is ignored.
- R10: Op codes 5, 6 and 7 change neither the latch nor the direction register, and they do not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; four clocks make one instruction cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A command is present; sampled only at the end of phase Q4 |
| op_code | input | 3 | 0 WRITE, 1 BSET, 2 BCLR, 3 READ, 4 DIRLOAD |
| op_bit | input | IDX_W (3) | Bit addressed by BSET or BCLR |
| op_data | input | PORT_W (8) | Byte for WRITE or DIRLOAD |
| pin_in | input | PORT_W (8) | Level seen on each pin |
| pin_out | output | PORT_W (8) | Output latch, presented to the pin drivers |
| pin_oe | output | PORT_W (8) | Per-pin driver enable; 1 means the pin drives |
| rd_data | output | PORT_W (8) | Pin levels returned by READ |
| rd_valid | output | 1 | `rd_data` is valid during this Q4 clock |
| cyc_phase | output | 2 | Current phase of the instruction cycle |

## Verification
Two functions share one clock edge: the commit of one instruction's latch write, and the pin sample of the next instruction. Both happen on the edge that closes Q4. The bench provokes this overlap in two ways. First, it issues a WRITE directly followed by a READ, and expects the older pin level, then the newer level on a later READ. Second, it runs chains of bit clears on a port with mixed directions, where inputs are held high externally, and judges the final latch and driven pins. A behavioural model tracks the phase, the latch, the direction register and the pending command. It is compared with the ports on every clock during the directed steps and during a pseudo-random stream of commands and external levels.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_WRITE = 3'd0;
  localparam logic [OPC_W-1:0] OPC_BSET  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_BCLR  = 3'd2;
  localparam logic [OPC_W-1:0] OPC_READ  = 3'd3;
  localparam logic [OPC_W-1:0] OPC_DIRLD = 3'd4;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  // True for the commands that rebuild the latch from sampled pin levels.
  function automatic logic op_is_rmw(input logic [OPC_W-1:0] op);
    return (op == OPC_BSET) || (op == OPC_BCLR);
  endfunction

  // True for every command that writes the output latch.
  function automatic logic op_hits_latch(input logic [OPC_W-1:0] op);
    return (op == OPC_WRITE) || op_is_rmw(op);
  endfunction

endpackage

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq
  import gpio_rmw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   take_cmd,
  output logic   modify_step,
  output logic   report_step
);

  phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_Q4;
    end else begin
      case (phase_q)
        PH_Q1:   phase_q <= PH_Q2;
        PH_Q2:   phase_q <= PH_Q3;
        PH_Q3:   phase_q <= PH_Q4;
        default: phase_q <= PH_Q1;
      endcase
    end
  end

  assign phase       = phase_q;
  assign take_cmd    = (phase_q == PH_Q4);
  assign modify_step = (phase_q == PH_Q2);
  assign report_step = (phase_q == PH_Q3);

endmodule

// File: rtl/gpio_rmw_alu.sv
module gpio_rmw_alu
  import gpio_rmw_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IMPL_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PORT_W-1:0] samp,
  input  logic [PORT_W-1:0] data,
  output logic [PORT_W-1:0] res_latch,
  output logic [PORT_W-1:0] res_dir,
  output logic              wr_latch,
  output logic              wr_dir
);

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (i < IMPL_W) begin : g_impl
      logic hit;
      assign hit = (idx == IDX_W'(i));
      assign res_latch[i] = (op == OPC_WRITE)        ? data[i] :
                            (op == OPC_BSET && hit)  ? 1'b1    :
                            (op == OPC_BCLR && hit)  ? 1'b0    :
                                                       samp[i];
      assign res_dir[i] = data[i];
    end else begin : g_gap
      // Absent bits: latch held at 0, direction held at input.
      assign res_latch[i] = 1'b0 & (data[i] | samp[i]);
      assign res_dir[i]   = 1'b1 | (data[i] & samp[i]);
    end
  end

  assign wr_latch = op_hits_latch(op);
  assign wr_dir   = (op == OPC_DIRLD);

endmodule

// File: rtl/gpio_rmw_regs.sv
module gpio_rmw_regs #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_wr,
  input  logic              dir_wr,
  input  logic [PORT_W-1:0] nxt_latch,
  input  logic [PORT_W-1:0] nxt_dir,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else begin
      if (latch_wr) latch_q <= nxt_latch;
      if (dir_wr)   dir_q   <= nxt_dir;
    end
  end

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IMPL_W = 6,
  localparam int IDX_W = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [IDX_W-1:0]  op_bit,
  input  logic [PORT_W-1:0] op_data,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [1:0]        cyc_phase
);

  localparam logic [PORT_W-1:0] IMPL_MASK = ~({PORT_W{1'b1}} << IMPL_W);

  phase_e phase;
  logic   take_cmd, modify_step, report_step;

  gpio_rmw_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .take_cmd    (take_cmd),
    .modify_step (modify_step),
    .report_step (report_step)
  );

  // Command and pin sample captured on the edge that starts Q1.
  logic              cmd_v;
  logic [OPC_W-1:0]  cmd_op;
  logic [IDX_W-1:0]  cmd_idx;
  logic [PORT_W-1:0] cmd_data;
  logic [PORT_W-1:0] samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v    <= 1'b0;
      cmd_op   <= OPC_WRITE;
      cmd_idx  <= '0;
      cmd_data <= '0;
      samp_q   <= '0;
    end else if (take_cmd) begin
      cmd_v    <= op_valid;
      cmd_op   <= op_code;
      cmd_idx  <= op_bit;
      cmd_data <= op_data;
      samp_q   <= pin_in & IMPL_MASK;
    end
  end

  // Modify step: result formed from the sample and held until Q4 ends.
  logic [PORT_W-1:0] alu_latch, alu_dir;
  logic              alu_wr_latch, alu_wr_dir;

  gpio_rmw_alu #(
    .PORT_W (PORT_W),
    .IMPL_W (IMPL_W),
    .IDX_W  (IDX_W)
  ) u_alu (
    .op        (cmd_op),
    .idx       (cmd_idx),
    .samp      (samp_q),
    .data      (cmd_data),
    .res_latch (alu_latch),
    .res_dir   (alu_dir),
    .wr_latch  (alu_wr_latch),
    .wr_dir    (alu_wr_dir)
  );

  logic [PORT_W-1:0] work_latch, work_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_latch <= '0;
      work_dir   <= '1;
    end else if (modify_step) begin
      work_latch <= alu_latch & IMPL_MASK;
      work_dir   <= alu_dir | ~IMPL_MASK;
    end
  end

  // Named commit events, also observed by the checker.
  logic commit_en, latch_wr, dir_wr;
  assign commit_en = take_cmd & cmd_v;
  assign latch_wr  = commit_en & alu_wr_latch;
  assign dir_wr    = commit_en & alu_wr_dir;

  logic [PORT_W-1:0] latch_q, dir_q;

  gpio_rmw_regs #(
    .PORT_W (PORT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_wr  (latch_wr),
    .dir_wr    (dir_wr),
    .nxt_latch (work_latch),
    .nxt_dir   (work_dir),
    .latch_q   (latch_q),
    .dir_q     (dir_q)
  );

  // Read result presented during Q4.
  logic              rdv_q;
  logic [PORT_W-1:0] rdd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else if (report_step) begin
      rdv_q <= cmd_v && (cmd_op == OPC_READ);
      rdd_q <= samp_q;
    end else if (take_cmd) begin
      rdv_q <= 1'b0;
    end
  end

  assign pin_out   = latch_q;
  assign pin_oe    = ~dir_q;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;
  assign cyc_phase = phase;

endmodule

// File: rtl/gpio_rmw_port_chk.sv
module gpio_rmw_port_chk #(
  parameter int PORT_W = 8,
  parameter int IMPL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cyc_phase,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              latch_wr,
  input logic              dir_wr
);

  localparam logic [PORT_W-1:0] GAP_MASK = {PORT_W{1'b1}} << IMPL_W;

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_phase == 2'd3) |=> (cyc_phase == 2'd0));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_phase != 2'd3) |=> (cyc_phase == $past(cyc_phase) + 2'd1));

  assert_latch_moves_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(latch_wr));

  assert_oe_moves_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(dir_wr));

  assert_read_in_q4_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cyc_phase == 2'd3));

  assert_read_single_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_gap_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_oe | rd_data) & GAP_MASK) == '0);

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_wr && dir_wr));

endmodule

bind gpio_rmw_port gpio_rmw_port_chk #(
  .PORT_W (PORT_W),
  .IMPL_W (IMPL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_phase (cyc_phase),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .latch_wr  (latch_wr),
  .dir_wr    (dir_wr)
);

// File: tb/gpio_rmw_port_tb.sv
`timescale 1ns/1ps
module gpio_rmw_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [2:0] op_bit = 3'd0;
  logic [7:0] op_data = 8'h00;
  logic [7:0] ext_lvl = 8'h00;
  logic       done = 1'b0;

  wire [7:0] pin_in, pin_out, pin_oe, rd_data;
  wire       rd_valid;
  wire [1:0] cyc_phase;

  // External drivers act only where the port does not drive.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_rmw_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_bit    (op_bit),
    .op_data   (op_data),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .cyc_phase (cyc_phase)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int misses  = 0;

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  logic [7:0] m_latch = 8'h00, m_dir = 8'hFF, m_rd = 8'h00;
  logic [7:0] p_data = 8'h00, p_samp = 8'h00;
  logic [2:0] p_op = 3'd0, p_bit = 3'd0;
  logic       p_v = 1'b0, m_rdv = 1'b0;
  int         m_ph = 3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = 8'h00; m_dir = 8'hFF; m_ph = 3; p_v = 1'b0; m_rdv = 1'b0;
    end else begin
      if (m_ph == 3) begin
        logic [7:0] pins;
        pins = ((m_latch & ~m_dir) | (ext_lvl & m_dir)) & 8'h3F;
        if (p_v) begin
          case (p_op)
            3'd0: m_latch = p_data & 8'h3F;
            3'd1: m_latch = (p_samp | (8'h01 << p_bit)) & 8'h3F;
            3'd2: m_latch = (p_samp & ~(8'h01 << p_bit)) & 8'h3F;
            3'd4: m_dir   = p_data | 8'hC0;
            default: ;
          endcase
        end
        m_rdv  = 1'b0;
        p_v    = op_valid;
        p_op   = op_code;
        p_bit  = op_bit;
        p_data = op_data;
        p_samp = pins;
      end else if (m_ph == 2) begin
        m_rdv = p_v && (p_op == 3'd3);
        m_rd  = p_samp;
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check8("R2 phase", {6'd0, cyc_phase}, 8'(m_ph));
      check8("R4 latch", pin_out, m_latch);
      check8("R5 enable", pin_oe, ~m_dir);
      check8("R6 valid", {7'd0, rd_valid}, {7'd0, m_rdv});
      if (m_rdv) check8("R6 data", rd_data, m_rd);
    end
  end

  task automatic issue(input logic v, input logic [2:0] op, input logic [2:0] b, input logic [7:0] d);
    @(negedge clk);
    while (cyc_phase !== 2'd3) @(negedge clk);
    op_valid = v; op_code = op; op_bit = b; op_data = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic nop();
    issue(1'b0, 3'd0, 3'd0, 8'h00);
  endtask

  task automatic read_expect(input logic [7:0] exp, input string tag);
    issue(1'b1, 3'd3, 3'd0, 8'h00);
    while (cyc_phase !== 2'd3) @(negedge clk);
    check8({tag, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
    check8({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    repeat (3) @(negedge clk);
    check8("R1 pin_out", pin_out, 8'h00);
    check8("R1 pin_oe", pin_oe, 8'h00);
    check8("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
    check8("R2 reset phase", {6'd0, cyc_phase}, 8'h03);
    rst_n = 1'b1;
    ext_lvl = 8'hF0;

    // R3, R8: full write, absent bits ignored
    issue(1'b1, 3'd0, 3'd0, 8'hFF); nop();
    check8("R3 write", pin_out, 8'h3F);
    check8("R8 absent bits", pin_out & 8'hC0, 8'h00);

    // R4, R5: mixed directions, inputs 5 and 4 held high
    issue(1'b1, 3'd4, 3'd0, 8'h38);
    issue(1'b1, 3'd0, 3'd0, 8'h10); nop();
    issue(1'b1, 3'd2, 3'd5, 8'h00);
    issue(1'b1, 3'd2, 3'd4, 8'h00);
    issue(1'b1, 3'd4, 3'd0, 8'h07); nop();
    check8("R4 clear chain latch", pin_out, 8'h20);
    check8("R5 enable after load", pin_oe, 8'h38);

    // R7: read right after write sees the old level
    issue(1'b1, 3'd4, 3'd0, 8'h00); nop();
    issue(1'b1, 3'd0, 3'd0, 8'h15);
    read_expect(8'h20, "R7 stale");
    @(negedge clk);
    check8("R6 valid drops", {7'd0, rd_valid}, 8'h00);
    read_expect(8'h15, "R7 fresh");

    // R8: set on absent bits, read of absent pins
    issue(1'b1, 3'd1, 3'd6, 8'h00);
    issue(1'b1, 3'd1, 3'd7, 8'h00); nop();
    check8("R8 set absent bit", pin_out, 8'h15);
    issue(1'b1, 3'd4, 3'd0, 8'hFF); nop();
    ext_lvl = 8'hFF;
    read_expect(8'h3F, "R8 read mask");
    check8("R8 enable", pin_oe, 8'h00);

    // R9: invalid slot and off-phase command
    issue(1'b0, 3'd0, 3'd0, 8'hAA); nop();
    check8("R9 no valid", pin_out, 8'h15);
    @(negedge clk);
    while (cyc_phase !== 2'd1) @(negedge clk);
    op_valid = 1'b1; op_code = 3'd0; op_data = 8'h2A;
    @(negedge clk); @(negedge clk);
    op_valid = 1'b0;
    nop(); nop();
    check8("R9 off phase", pin_out, 8'h15);

    // R10: undefined codes
    issue(1'b1, 3'd5, 3'd0, 8'h2A);
    issue(1'b1, 3'd7, 3'd0, 8'h00); nop();
    check8("R10 latch", pin_out, 8'h15);
    check8("R10 enable", pin_oe, 8'h00);

    // R4: set on an input pin copies the other input levels
    ext_lvl = 8'h0A;
    issue(1'b1, 3'd1, 3'd0, 8'h00); nop();
    check8("R4 set from pins", pin_out, 8'h0B);

    // Pseudo-random stream, judged by the model every clock
    lfsr = 16'hACE1;
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ext_lvl = lfsr[15:8];
      issue(1'b1, 3'(lfsr[7:0] % 6), lfsr[2:0], lfsr[11:4]);
    end
    nop(); nop();
    finish_run();
  end

endmodule